// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps eight ownership tokens that two independent ports, named left and right, share. Each port runs on the common clock. A port selects the bank by driving its semaphore select low while its memory enable is high, so the memory is not selected. The low address bits pick a token. Writing 0 on data bit 0 asks for the token. Writing 1 gives the token back, or withdraws a request that is still waiting.

A port learns whether it holds a token by reading it. The bank answers 0 to the holder and 1 to everyone else, with that bit copied onto every data line. Each token also stores a request made by the side that does not hold it, so ownership moves to that side on the same clock edge at which the holder releases it. When both sides ask for a free token in the same cycle, the left side gets it and the right request is kept waiting. Read data leaves through a register on each port. A value the port has already read does not move when the other port writes in the same cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free with no stored request, and both read-data buses are all ones.
- R2: A port takes part only while its select is 0 and its memory enable is 1. Any other combination neither changes a token nor loads read data.
- R3: Address bits [2:0] choose the token. The remaining address bits have no effect.
- R4: A write looks only at data bit 0, where 0 asks for the token and 1 releases it or withdraws a waiting request. Data bits above bit 0 are ignored.
- R5: A request on a free token gives it to the requester on the next clock edge. From then on the holder reads 0 and the other side reads 1.
- R6: While one side holds a token, writes from the other side never take it away or free it.
- R7: A request written by the non-holding side is remembered. When the holder writes 1, ownership passes straight to the waiting side.
- R8: When the holder releases and no request is waiting, the token becomes free and both sides read 1.
- R9: If the non-holding side writes 1, its waiting request is cleared, so a later release leaves the token free.
- R10: A read loads rdata on the clock edge that samples it, with the token's view (0 if this port holds it, otherwise 1) on every data bit. rdata then holds until the next read on that port.
- R11: If both sides request the same free token in the same cycle, the left side owns it and the right request stays waiting.
- R12: A read returns the token state from before any write sampled on the same edge, whether that write comes from this port or the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_mem_n | input | 1 | Left memory enable, active low (must be 1 for token access) |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left address; bits [2:0] choose the token |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_mem_n | input | 1 | Right memory enable, active low (must be 1 for token access) |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right address; bits [2:0] choose the token |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The bench targets the cases where ownership depends on ordering.

- **Same-cycle requests.** Both sides request one free token in the same cycle. A design that lets the right side win, or drops the losing request, hands over the wrong token or never hands it over later.
- **Release against a waiting request.** The holder releases on the same edge that a waiting reader samples. A design that reads after the write instead of before it returns 0 one cycle early.
- **Withdrawn requests.** The non-holding side cancels its request before the holder releases. A design that forgets to clear the waiting request passes the token to a side that no longer wants it.
- **Ignored inputs.** Blocked accesses, high address bits and high data bits are driven with varied values. A design that decodes any of them changes tokens that should not move.

// File: rtl/sem_bank_pkg.sv
`timescale 1ns/1ps
package sem_bank_pkg;

    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_owner_e;

    typedef struct packed {
        tok_owner_e owner;
        logic       wait_l;   // left asked while right holds
        logic       wait_r;   // right asked while left holds
    } tok_state_t;

    typedef struct packed {
        logic hit;            // write to this token this cycle
        logic val;            // data bit 0 of that write
    } tok_wr_t;

    localparam tok_state_t TOK_RESET = '{owner: TOK_FREE, wait_l: 1'b0, wait_r: 1'b0};

    // Next token state from the two per-token write strobes
    function automatic tok_state_t tok_next(tok_state_t cur, tok_wr_t wl, tok_wr_t wr);
        tok_state_t nx;
        logic req_l, rel_l, req_r, rel_r, want;
        nx    = cur;
        req_l = wl.hit && !wl.val;
        rel_l = wl.hit &&  wl.val;
        req_r = wr.hit && !wr.val;
        rel_r = wr.hit &&  wr.val;
        want  = 1'b0;
        case (cur.owner)
            TOK_FREE: begin
                nx.wait_l = 1'b0;
                nx.wait_r = 1'b0;
                if (req_l) begin
                    nx.owner  = TOK_LEFT;
                    nx.wait_r = req_r;      // left wins a tie, right waits
                end else if (req_r) begin
                    nx.owner  = TOK_RIGHT;
                end
            end
            TOK_LEFT: begin
                want = cur.wait_r;
                if (req_r) want = 1'b1;
                if (rel_r) want = 1'b0;
                nx.wait_l = 1'b0;
                if (rel_l) begin
                    nx.owner  = want ? TOK_RIGHT : TOK_FREE;
                    nx.wait_r = 1'b0;
                end else begin
                    nx.wait_r = want;
                end
            end
            TOK_RIGHT: begin
                want = cur.wait_l;
                if (req_l) want = 1'b1;
                if (rel_l) want = 1'b0;
                nx.wait_r = 1'b0;
                if (rel_r) begin
                    nx.owner  = want ? TOK_LEFT : TOK_FREE;
                    nx.wait_l = 1'b0;
                end else begin
                    nx.wait_l = want;
                end
            end
            default: nx = TOK_RESET;
        endcase
        return nx;
    endfunction

    // Read-back bit seen from one side: 0 only for the holder
    function automatic logic tok_view(tok_owner_e owner, logic is_left);
        if (is_left) return (owner == TOK_LEFT)  ? 1'b0 : 1'b1;
        else         return (owner == TOK_RIGHT) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
`timescale 1ns/1ps
module sem_port_decode
    import sem_bank_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 9,
    localparam int SEL_W  = $clog2(NUM_SEM)
) (
    input  logic                    sem_n,
    input  logic                    mem_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output tok_wr_t [NUM_SEM-1:0]   wstb,
    output logic                    rd_en,
    output logic [SEL_W-1:0]        rd_idx
);
    logic             acc;
    logic [SEL_W-1:0] idx;
    logic             unused_bits;

    assign acc    = !sem_n && mem_n;
    assign idx    = addr[SEL_W-1:0];
    assign rd_en  = acc && !wr;
    assign rd_idx = idx;

    // upper address and data bits play no part in token access
    assign unused_bits = ^{addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_strobe
        assign wstb[g].hit = acc && wr && (idx == SEL_W'(g));
        assign wstb[g].val = wdata[0];
    end

endmodule

// File: rtl/sem_token_cell.sv
`timescale 1ns/1ps
module sem_token_cell
    import sem_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tok_wr_t wl,
    input  tok_wr_t wr,
    output logic    view_l,
    output logic    view_r
);
    tok_state_t st;

    always_ff @(posedge clk) begin
        if (rst) st <= TOK_RESET;
        else     st <= tok_next(st, wl, wr);
    end

    assign view_l = tok_view(st.owner, 1'b1);
    assign view_r = tok_view(st.owner, 1'b0);

    // R5
    req_free_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_FREE && wl.hit && !wl.val) |=> (st.owner == TOK_LEFT));
    // R11
    tie_left_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_FREE && wl.hit && !wl.val && wr.hit && !wr.val)
        |=> (st.owner == TOK_LEFT && st.wait_r));
    // R6
    hold_left_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_LEFT && !wl.hit) |=> (st.owner == TOK_LEFT));
    // R6
    hold_right_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_RIGHT && !wr.hit) |=> (st.owner == TOK_RIGHT));
    // R7
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_LEFT && wl.hit && wl.val && st.wait_r && !wr.hit)
        |=> (st.owner == TOK_RIGHT));
    // R8
    release_free_chk: assert property (@(posedge clk) disable iff (rst)
        (st.owner == TOK_RIGHT && wr.hit && wr.val && !st.wait_l && !wl.hit)
        |=> (st.owner == TOK_FREE && view_l && view_r));
    // R7
    wait_owner_chk: assert property (@(posedge clk) disable iff (rst)
        st.wait_r |-> (st.owner == TOK_LEFT));

endmodule

// File: rtl/sem_read_latch.sv
`timescale 1ns/1ps
module sem_read_latch #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9,
    localparam int SEL_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] views,
    output logic [DATA_W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (rst)        rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{views[rd_idx]}};
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
    // R10
    rd_copy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rdata == {DATA_W{$past(views[rd_idx])}}));

endmodule

// File: rtl/sem_bank.sv
`timescale 1ns/1ps
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_mem_n,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_mem_n,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int SEL_W = $clog2(NUM_SEM);

    tok_wr_t [NUM_SEM-1:0] l_stb, r_stb;
    logic                  l_rd, r_rd;
    logic [SEL_W-1:0]      l_idx, r_idx;
    logic [NUM_SEM-1:0]    l_view, r_view;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sem_n(l_sem_n), .mem_n(l_mem_n), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
        .wstb(l_stb), .rd_en(l_rd), .rd_idx(l_idx)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sem_n(r_sem_n), .mem_n(r_mem_n), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
        .wstb(r_stb), .rd_en(r_rd), .rd_idx(r_idx)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_tok
        sem_token_cell u_cell (
            .clk(clk), .rst(rst),
            .wl(l_stb[g]), .wr(r_stb[g]),
            .view_l(l_view[g]), .view_r(r_view[g])
        );
    end

    sem_read_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst(rst), .rd_en(l_rd), .rd_idx(l_idx), .views(l_view), .rdata(l_rdata)
    );

    sem_read_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst(rst), .rd_en(r_rd), .rd_idx(r_idx), .views(r_view), .rdata(r_rdata)
    );

    // R2
    blocked_l_chk: assert property (@(posedge clk) disable iff (rst)
        (l_sem_n || !l_mem_n) |=> $stable(l_rdata));
    // R6
    one_holder_chk: assert property (@(posedge clk) disable iff (rst)
        ((l_view | r_view) == {NUM_SEM{1'b1}}));

endmodule

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
    localparam int NUM_SEM = 8;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 9;
    localparam logic [DATA_W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sem_n = 1'b1, l_mem_n = 1'b1, l_wr = 1'b0;
    logic r_sem_n = 1'b1, r_mem_n = 1'b1, r_wr = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    always #5 clk = ~clk;

    sem_bank #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

    // reference state: 0 free, 1 left holds, 2 right holds
    int m_own[NUM_SEM];
    bit m_wl[NUM_SEM], m_wr[NUM_SEM];
    logic [DATA_W-1:0] exp_l, exp_r;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] view(int own, bit left);
        if (own == (left ? 1 : 2)) return '0;
        return ONES;
    endfunction

    task automatic model_apply(bit lh, bit lv, int li, bit rh, bit rv, int ri);
        for (int i = 0; i < NUM_SEM; i++) begin
            bit ql = lh && li == i && !lv, xl = lh && li == i && lv;
            bit qr = rh && ri == i && !rv, xr = rh && ri == i && rv;
            if (m_own[i] == 0) begin
                if (ql) begin m_own[i] = 1; m_wr[i] = qr; end
                else if (qr) m_own[i] = 2;
            end else if (m_own[i] == 1) begin
                if (qr) m_wr[i] = 1;
                if (xr) m_wr[i] = 0;
                if (xl) begin m_own[i] = m_wr[i] ? 2 : 0; m_wr[i] = 0; end
            end else begin
                if (ql) m_wl[i] = 1;
                if (xl) m_wl[i] = 0;
                if (xr) begin m_own[i] = m_wl[i] ? 1 : 0; m_wl[i] = 0; end
            end
        end
    endtask

    // one cycle on both ports, inputs driven at the falling edge
    task automatic step(string tag,
                        bit ls, bit lm, bit lw, logic [ADDR_W-1:0] la, logic [DATA_W-1:0] ld,
                        bit rs, bit rm, bit rw, logic [ADDR_W-1:0] ra, logic [DATA_W-1:0] rd);
        bit la_ok, ra_ok;
        l_sem_n = ls; l_mem_n = lm; l_wr = lw; l_addr = la; l_wdata = ld;
        r_sem_n = rs; r_mem_n = rm; r_wr = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        la_ok = !ls && lm;
        ra_ok = !rs && rm;
        if (la_ok && !lw) exp_l = view(m_own[la[2:0]], 1'b1);
        if (ra_ok && !rw) exp_r = view(m_own[ra[2:0]], 1'b0);
        model_apply(la_ok && lw, ld[0], int'(la[2:0]), ra_ok && rw, rd[0], int'(ra[2:0]));
        @(negedge clk);
        check({tag, " left"},  l_rdata, exp_l);
        check({tag, " right"}, r_rdata, exp_r);
    endtask

    // op: 0 idle, 1 read, 2 write
    task automatic op(string tag, int lop, int li, bit lv, int rop, int ri, bit rv);
        step(tag, lop == 0, 1'b1, lop == 2, ADDR_W'(li), DATA_W'(lv),
                  rop == 0, 1'b1, rop == 2, ADDR_W'(ri), DATA_W'(rv));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_SEM; i++) begin m_own[i] = 0; m_wl[i] = 0; m_wr[i] = 0; end
        exp_l = ONES; exp_r = ONES;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset left", l_rdata, ONES);
        check("R1 reset right", r_rdata, ONES);
        for (int i = 0; i < NUM_SEM; i++) op("R1 all free", 1, i, 0, 1, i, 0);

        // R5: left takes free token 2
        op("R5 request", 2, 2, 0, 0, 0, 0);
        op("R5 readback", 1, 2, 0, 1, 2, 0);
        check("R5 holder reads 0", l_rdata, '0);
        check("R5 other reads 1", r_rdata, ONES);
        // R6: right release attempt does nothing
        op("R6 foreign release", 0, 0, 0, 2, 2, 1);
        op("R6 still held", 1, 2, 0, 1, 2, 0);
        check("R6 left still holds", l_rdata, '0);
        // R7: right waits, left releases, right gets it
        op("R7 right waits", 0, 0, 0, 2, 2, 0);
        op("R7 left releases", 2, 2, 1, 0, 0, 0);
        op("R7 readback", 1, 2, 0, 1, 2, 0);
        check("R7 right now holds", r_rdata, '0);
        check("R7 left lost", l_rdata, ONES);
        // R8: right releases, token free
        op("R8 release", 0, 0, 0, 2, 2, 1);
        op("R8 readback", 1, 2, 0, 1, 2, 0);
        check("R8 both one", l_rdata & r_rdata, ONES);
        // R9: cancel waiting request
        op("R9 left takes 5", 2, 5, 0, 0, 0, 0);
        op("R9 right waits", 0, 0, 0, 2, 5, 0);
        op("R9 right cancels", 0, 0, 0, 2, 5, 1);
        op("R9 left releases", 2, 5, 1, 0, 0, 0);
        op("R9 readback", 1, 5, 0, 1, 5, 0);
        check("R9 token free", l_rdata & r_rdata, ONES);
        // R11: same-cycle requests
        op("R11 tie", 2, 7, 0, 2, 7, 0);
        op("R11 readback", 1, 7, 0, 1, 7, 0);
        check("R11 left wins", l_rdata, '0);
        op("R11 left releases", 2, 7, 1, 0, 0, 0);
        op("R11 right got it", 0, 0, 0, 1, 7, 0);
        check("R11 right holds after release", r_rdata, '0);
        op("R11 cleanup", 0, 0, 0, 2, 7, 1);
        // R12: read sees state before a same-edge write
        op("R12 left takes 4", 2, 4, 0, 0, 0, 0);
        op("R12 right waits", 0, 0, 0, 2, 4, 0);
        op("R12 release with read", 2, 4, 1, 1, 4, 0);
        check("R12 pre-write value", r_rdata, ONES);
        op("R12 after", 0, 0, 0, 1, 4, 0);
        check("R12 post-write value", r_rdata, '0);
        op("R12 cleanup", 0, 0, 0, 2, 4, 1);
        // R2: blocked accesses
        step("R2 mem enabled write", 1'b0, 1'b0, 1'b1, 14'd3, 9'd0, 1'b1, 1'b1, 1'b0, 14'd0, 9'd0);
        step("R2 unselected write",  1'b1, 1'b1, 1'b1, 14'd3, 9'd0, 1'b1, 1'b1, 1'b0, 14'd0, 9'd0);
        op("R2 readback", 1, 3, 0, 1, 3, 0);
        check("R2 token 3 free", l_rdata & r_rdata, ONES);
        op("R10 set left 0", 2, 6, 0, 0, 0, 0);
        op("R10 read 0", 1, 6, 0, 0, 0, 0);
        step("R10 blocked read holds", 1'b0, 1'b0, 1'b0, 14'd1, 9'd0, 1'b1, 1'b1, 1'b0, 14'd0, 9'd0);
        check("R10 rdata held", l_rdata, '0);
        op("R10 cleanup", 2, 6, 1, 0, 0, 0);
        // R3: high address bits ignored
        step("R3 write high addr", 1'b0, 1'b1, 1'b1, 14'h3FF9, 9'd0, 1'b1, 1'b1, 1'b0, 14'd0, 9'd0);
        step("R3 read other high", 1'b0, 1'b1, 1'b0, 14'h2A01, 9'd0, 1'b0, 1'b1, 1'b0, 14'h1001, 9'd0);
        check("R3 token 1 held", l_rdata, '0);
        // R4: only bit 0 of write data counts
        step("R4 release via 1FF", 1'b0, 1'b1, 1'b1, 14'd1, 9'h1FF, 1'b1, 1'b1, 1'b0, 14'd0, 9'd0);
        step("R4 request via 1FE", 1'b1, 1'b1, 1'b0, 14'd0, 9'd0, 1'b0, 1'b1, 1'b1, 14'd1, 9'h1FE);
        op("R4 readback", 1, 1, 0, 1, 1, 0);
        check("R4 right holds", r_rdata, '0);

        // random phase
        void'($urandom(32'h5EED_0001));
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a = $urandom, b = $urandom;
            step("RND R5 R6 R7 R8 R9 R11 R12",
                 a[0] | a[1], a[2] | a[3] | a[4], a[5], ADDR_W'(a[31:18]), DATA_W'(a[17:9]),
                 b[0] | b[1], b[2] | b[3] | b[4], b[5], ADDR_W'(b[31:18]), DATA_W'(b[17:9]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule